// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Timer

This block turns host-side programmed-I/O requests into read and write strobe cycles on a parallel ATA primary channel. A 16-bit timing word, held elsewhere in the system bus clock domain, is presented as a plain input. Its top bit, together with a separate I/O-space enable, decides whether the legacy command block (eight byte addresses from 1F0h) and the control address 3F6h are claimed at all. Bit 14 chooses whether drive 1 shares the main timing fields or uses a separate four-bit slave timing input.

A claimed request drives one chip select, the low three address bits and the matching active-low strobe. The device ready line is first sampled a programmed number of clocks after the strobe goes low. The strobe then stays low until ready is seen high. A programmed recovery gap follows the last sample, and the request port is held not-ready until the gap has run out. A request to an unclaimed address finishes on the next clock and drives no strobe. The drive whose timing applies is taken from bit 4 of every claimed write to 1F6h.

Top module: `pata_pio_timer`

## Requirements
- R1: A request is claimed only when timing_i[15] and io_space_en_i are both 1 and the address is in 1F0h..1F7h (cs0_n_o low) or equals 3F6h (cs1_n_o low). During the cycle da_o carries address bits 2:0. Outside a cycle both chip selects are high and da_o is 0.
- R2: An unclaimed request gives resp_valid_o high for one clock, on the clock after acceptance, with resp_claimed_o 0 and resp_rdata_o 0. No strobe is asserted.
- R3: A claimed read drives dior_n_o low from the clock after acceptance. A claimed write drives diow_n_o low, dd_oe_o high and dd_o with the write data. The two strobes are never low together.
- R4: The ready-sample field (timing bits 13:12, or slave bits 3:2) gives the number of clocks from strobe assertion to the first ready sample: 00 gives 5, 01 gives 4, 10 gives 3, and 11 gives 3. With ready high, the strobe is low for exactly that many clocks.
- R5: While ready is low at a sample, the strobe stays low and ready is sampled again on every clock.
- R6: The cycle ends on the clock edge where ready is sampled high. A read latches dd_i on that edge. resp_valid_o and resp_claimed_o are then 1 for one clock, with that data (0 for writes).
- R7: The recovery field (timing bits 9:8, or slave bits 1:0) gives the minimum clocks from the last ready sample to the next strobe: 00 gives 4, 01 gives 3, 10 gives 2, 11 gives 1. req_ready_o stays low until the gap has expired.
- R8: A claimed write to 1F6h sets the selected drive to req_wdata_i[4]. The new drive applies from the next request on.
- R9: With timing_i[14] at 0, both drives use the main fields. With it at 1, drive 1 uses slave_timing_i.
- R10: After reset both strobes are high, req_ready_o is 1, resp_valid_o is 0 and drive 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_i | input | 16 | Primary timing word |
| io_space_en_i | input | 1 | I/O space enable from the command register |
| slave_timing_i | input | 4 | Drive 1 timing: bits 3:2 sample code, bits 1:0 recovery code |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted when high with valid |
| req_addr_i | input | 16 | I/O address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| resp_valid_o | output | 1 | One-clock completion pulse |
| resp_claimed_o | output | 1 | Completed request was claimed |
| resp_rdata_o | output | 16 | Read data |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| cs0_n_o | output | 1 | Command block select, active low |
| cs1_n_o | output | 1 | Control block select, active low |
| da_o | output | 3 | Device register address |
| dd_o | output | 16 | Data to device |
| dd_oe_o | output | 1 | Data output enable |
| dd_i | input | 16 | Data from device |
| iordy_i | input | 1 | Device ready |

## Verification
The hardest case is drive 1 taking its timing from the slave field. Reaching it needs the decode enabled, a claimed write to 1F6h with bit 4 set, and bit 14 raised before a later read. The stimulus builds that order one request at a time and measures the read strobe width against the slave sample code. It then clears bit 14, and after that writes drive 0 back, to show the main fields return. Holding ready low across several sample points while a back-to-back request waits on recovery is the other hard case. A behavioural model in the bench, built on time stamps, follows both cases clock by clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} pio_state_e;

  // reserved sample code 11 behaves as 10
  function automatic logic [2:0] sample_clocks(logic [1:0] code);
    case (code)
      2'b00:   return 3'd5;
      2'b01:   return 3'd4;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic [2:0] recovery_clocks(logic [1:0] code);
    return 3'd4 - {1'b0, code};
  endfunction
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CMD_BASE = 16'h01F0,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h03F6
) (
  input  logic              decode_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_cmd_o,
  output logic              hit_ctl_o
);
  assign hit_cmd_o = decode_en_i && (addr_i[ADDR_W-1:3] == CMD_BASE[ADDR_W-1:3]);
  assign hit_ctl_o = decode_en_i && (addr_i == CTL_ADDR);
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import pio_pkg::*;
(
  input  logic [15:0] timing_i,
  input  logic [3:0]  slave_timing_i,
  input  logic        drv1_i,
  output logic [2:0]  sample_n_o,
  output logic [2:0]  recov_n_o
);
  logic use_slave;
  assign use_slave  = drv1_i && timing_i[14];
  assign sample_n_o = sample_clocks(use_slave ? slave_timing_i[3:2] : timing_i[13:12]);
  assign recov_n_o  = recovery_clocks(use_slave ? slave_timing_i[1:0] : timing_i[9:8]);
endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
  import pio_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int DRV_BIT = 4,
  parameter logic [2:0] DRVHEAD_OFS = 3'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              hit_cmd_i,
  input  logic              hit_ctl_i,
  input  logic [2:0]        sample_n_i,
  input  logic [2:0]        recov_n_i,
  input  logic              iordy_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic              req_ready_o,
  output logic              drv1_o,
  output logic              dior_n_o,
  output logic              diow_n_o,
  output logic              cs0_n_o,
  output logic              cs1_n_o,
  output logic [2:0]        da_o,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  output logic              resp_valid_o,
  output logic              resp_claimed_o,
  output logic [DATA_W-1:0] resp_rdata_o
);
  pio_state_e        state;
  logic [2:0]        cnt, rec, rec_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, hit;

  assign hit         = hit_cmd_i || hit_ctl_i;
  assign req_ready_o = (state == ST_IDLE) && (rec == '0);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state          <= ST_IDLE;
      cnt            <= '0;
      rec            <= '0;
      rec_q          <= '0;
      wdata_q        <= '0;
      da_o           <= '0;
      cs0_n_o        <= 1'b1;
      cs1_n_o        <= 1'b1;
      drv1_o         <= 1'b0;
      resp_valid_o   <= 1'b0;
      resp_claimed_o <= 1'b0;
      resp_rdata_o   <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      if (state == ST_IDLE && rec != '0) rec <= rec - 3'd1;
      case (state)
        ST_IDLE: if (accept) begin
          if (hit) begin
            state   <= req_write_i ? ST_WRITE : ST_READ;
            cnt     <= sample_n_i - 3'd1;
            rec_q   <= recov_n_i;
            da_o    <= req_addr_i[2:0];
            cs0_n_o <= !hit_cmd_i;
            cs1_n_o <= !hit_ctl_i;
            wdata_q <= req_write_i ? req_wdata_i : '0;
            if (req_write_i && hit_cmd_i && req_addr_i[2:0] == DRVHEAD_OFS)
              drv1_o <= req_wdata_i[DRV_BIT];
          end else begin
            resp_valid_o   <= 1'b1;
            resp_claimed_o <= 1'b0;
            resp_rdata_o   <= '0;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 3'd1;
          else if (iordy_i) begin
            state          <= ST_IDLE;
            rec            <= rec_q - 3'd1;
            resp_valid_o   <= 1'b1;
            resp_claimed_o <= 1'b1;
            resp_rdata_o   <= (state == ST_READ) ? dd_i : '0;
            cs0_n_o        <= 1'b1;
            cs1_n_o        <= 1'b1;
            da_o           <= '0;
            wdata_q        <= '0;
          end
        end
      endcase
    end
  end

  assign dior_n_o = (state != ST_READ);
  assign diow_n_o = (state != ST_WRITE);
  assign dd_oe_o  = (state == ST_WRITE);
  assign dd_o     = wdata_q;

  p_unclaimed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit) |=> (resp_valid_o && !resp_claimed_o && dior_n_o && diow_n_o));
  p_first_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (cnt >= 3'd2 && cnt <= 3'd4));
  p_hold_not_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && cnt == '0 && !iordy_i) |=> (state == $past(state)));
  p_gap_no_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && rec != '0) |=> (state == ST_IDLE));
endmodule

// File: rtl/pata_pio_timer.sv
module pata_pio_timer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       timing_i,
  input  logic              io_space_en_i,
  input  logic [3:0]        slave_timing_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic              resp_claimed_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              dior_n_o,
  output logic              diow_n_o,
  output logic              cs0_n_o,
  output logic              cs1_n_o,
  output logic [2:0]        da_o,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  input  logic [DATA_W-1:0] dd_i,
  input  logic              iordy_i
);
  logic       hit_cmd, hit_ctl, drv1;
  logic [2:0] sample_n, recov_n;

  pio_addr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .decode_en_i (timing_i[15] && io_space_en_i),
    .addr_i      (req_addr_i),
    .hit_cmd_o   (hit_cmd),
    .hit_ctl_o   (hit_ctl)
  );

  pio_timing_sel i_tsel (
    .timing_i       (timing_i),
    .slave_timing_i (slave_timing_i),
    .drv1_i         (drv1),
    .sample_n_o     (sample_n),
    .recov_n_o      (recov_n)
  );

  pio_strobe_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .hit_cmd_i      (hit_cmd),
    .hit_ctl_i      (hit_ctl),
    .sample_n_i     (sample_n),
    .recov_n_i      (recov_n),
    .iordy_i, .dd_i, .req_ready_o,
    .drv1_o         (drv1),
    .dior_n_o, .diow_n_o, .cs0_n_o, .cs1_n_o, .da_o, .dd_o, .dd_oe_o,
    .resp_valid_o, .resp_claimed_o, .resp_rdata_o
  );

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_n_o && !diow_n_o));
  p_cs_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~cs0_n_o, ~cs1_n_o}) <= 1);
endmodule

// File: tb/test_pata_pio_timer.sv
module test_pata_pio_timer;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [15:0] timing_i = 16'h0000;
  logic        io_space_en_i = 1'b1;
  logic [3:0]  slave_timing_i = 4'h0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0, dd_i = 16'hA5C3;
  logic        iordy_i = 1'b1;
  logic        req_ready_o, resp_valid_o, resp_claimed_o, dior_n_o, diow_n_o;
  logic        cs0_n_o, cs1_n_o, dd_oe_o;
  logic [15:0] resp_rdata_o, dd_o;
  logic [2:0]  da_o;

  int n_tests = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  pata_pio_timer i_pata_pio_timer (.*);

  // behavioural model keyed on edge time stamps
  int cyc = 0, m_start = 0, m_samp = 0, m_last = -100, m_rec = 1;
  bit m_busy = 0, m_wr = 0, m_drv = 0, m_acc = 0, m_resp = 0, m_claim = 0;
  bit m_cmd = 0, m_ctl = 0;
  logic [15:0] m_addr = '0, m_wdata = '0, m_rdata = '0;

  function automatic int samp_of(logic [1:0] c);
    case (c) 2'b00: return 5; 2'b01: return 4; default: return 3; endcase
  endfunction
  function automatic int rec_of(logic [1:0] c);
    case (c) 2'b00: return 4; 2'b01: return 3; 2'b10: return 2; default: return 1; endcase
  endfunction
  function automatic bit m_ready();
    return !m_busy && (cyc >= m_last + m_rec - 1);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc = 0; m_busy = 0; m_last = -100; m_rec = 1; m_drv = 0;
      m_acc = 0; m_resp = 0; m_claim = 0; m_rdata = '0;
    end else begin
      bit rdy, en, hc, hl, sl;
      rdy = m_ready();
      cyc = cyc + 1;
      m_acc = 0; m_resp = 0;
      if (m_busy) begin
        if (cyc >= m_start + m_samp && iordy_i) begin
          m_busy = 0; m_last = cyc; m_resp = 1; m_claim = 1;
          m_rdata = m_wr ? 16'h0 : dd_i;
        end
      end else if (req_valid_i && rdy) begin
        m_acc = 1;
        en = timing_i[15] && io_space_en_i;
        hc = en && req_addr_i >= 16'h01F0 && req_addr_i <= 16'h01F7;
        hl = en && req_addr_i == 16'h03F6;
        if (hc || hl) begin
          sl = m_drv && timing_i[14];
          m_busy = 1; m_start = cyc; m_wr = req_write_i; m_addr = req_addr_i;
          m_cmd = hc; m_ctl = hl; m_wdata = req_write_i ? req_wdata_i : 16'h0;
          m_samp = samp_of(sl ? slave_timing_i[3:2] : timing_i[13:12]);
          m_rec  = rec_of(sl ? slave_timing_i[1:0] : timing_i[9:8]);
          if (req_write_i && req_addr_i == 16'h01F6) m_drv = req_wdata_i[4];
        end else begin
          m_resp = 1; m_claim = 0; m_rdata = '0;
        end
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    check("R7", "req_ready_o", req_ready_o, m_ready());
    check("R3", "dior_n_o", dior_n_o, !(m_busy && !m_wr));
    check("R3", "diow_n_o", diow_n_o, !(m_busy && m_wr));
    check("R3", "dd_oe_o", dd_oe_o, m_busy && m_wr);
    check("R3", "dd_o", dd_o, m_busy ? m_wdata : 16'h0);
    check("R1", "cs0_n_o", cs0_n_o, !(m_busy && m_cmd));
    check("R1", "cs1_n_o", cs1_n_o, !(m_busy && m_ctl));
    check("R1", "da_o", da_o, m_busy ? m_addr[2:0] : 3'd0);
    check("R2", "resp_valid_o", resp_valid_o, m_resp);
    if (m_resp) begin
      check("R2", "resp_claimed_o", resp_claimed_o, m_claim);
      check("R6", "resp_rdata_o", resp_rdata_o, m_rdata);
    end
  end

  int width;
  bit claimed;

  task automatic run_req(logic [15:0] a, bit wr, logic [15:0] wd);
    int guard = 0;
    width = 0;
    @(negedge clk_i);
    req_addr_i = a; req_write_i = wr; req_wdata_i = wd; req_valid_i = 1'b1;
    do begin
      @(negedge clk_i);
      if (m_acc) req_valid_i = 1'b0;
      if (!dior_n_o || !diow_n_o) width++;
      guard++;
    end while (!resp_valid_o && guard < 200);
    claimed = resp_claimed_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    check("R10", "reset strobes", {dior_n_o, diow_n_o}, 2'b11);
    check("R10", "reset ready", req_ready_o, 1);
    check("R10", "reset resp", resp_valid_o, 0);

    // R1 decode off
    run_req(16'h01F0, 0, 0);
    check("R1", "disabled claim", claimed, 0);
    check("R1", "disabled strobe width", width, 0);
    timing_i = 16'h8000; io_space_en_i = 1'b0;
    run_req(16'h01F0, 0, 0);
    check("R1", "io space off claim", claimed, 0);
    io_space_en_i = 1'b1;

    // R4 code 00 -> 5
    dd_i = 16'h1234;
    run_req(16'h01F0, 0, 0);
    check("R4", "width code00", width, 5);
    check("R6", "read data", resp_rdata_o, 16'h1234);
    // back-to-back under recovery, code 01 sample -> 4
    timing_i = 16'h9000;
    run_req(16'h01F1, 0, 0);
    check("R4", "width code01", width, 4);
    timing_i = 16'hB000;
    run_req(16'h01F2, 1, 16'hBEEF);
    check("R4", "width code11", width, 3);
    timing_i = 16'hA300;
    run_req(16'h03F6, 0, 0);
    check("R1", "control claim", claimed, 1);
    run_req(16'h03F7, 0, 0);
    check("R2", "3F7 unclaimed", claimed, 0);
    run_req(16'h0170, 1, 16'h5555);
    check("R2", "170 unclaimed width", width, 0);

    // R5 ready held low
    timing_i = 16'hA100;
    iordy_i = 1'b0;
    fork
      run_req(16'h01F7, 0, 0);
      begin repeat (8) @(negedge clk_i); iordy_i = 1'b1; end
    join
    check("R5", "stretched width above 3", width > 3, 1);

    // R8/R9 drive 1 with slave timing
    timing_i = 16'hC000; slave_timing_i = 4'b1011;
    run_req(16'h01F6, 1, 16'h0010);
    check("R8", "1F6 write uses old drive", width, 5);
    run_req(16'h01F0, 0, 0);
    check("R9", "drive1 slave width", width, 3);
    timing_i = 16'h8000;
    run_req(16'h01F0, 0, 0);
    check("R9", "shared timing width", width, 5);
    timing_i = 16'hC000;
    run_req(16'h01F6, 1, 16'h00EF);
    run_req(16'h01F0, 0, 0);
    check("R8", "drive0 restored width", width, 5);
    timing_i = 16'hF000;
    run_req(16'h01F6, 1, 16'h0010);
    check("R4", "code11 width", width, 3);
    run_req(16'h01F4, 0, 0);
    check("R9", "slave code10 width", width, 3);

    repeat (6) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule